// File: doc/BRIEF.md
# PLL Clock Control Sequencer

This block is the digital control side of a clock multiplier. Software programs it through a small write/read register bus. It holds a multiplier, a post-divide selection, two peripheral prescaler fields and a write-protect release flag. The multiplier itself is treated as an ideal multiply. The block produces single-cycle clock-enable pulses on the fast core clock at the average rate that the programmed settings ask for. These are a system enable and a high-speed and a low-speed peripheral enable, each derived from the system enable.

A sequencer with three named states governs the rate source. **STABLE** runs at the multiplied and divided rate. **RELOCK** is entered by transition *accept* when a multiplier change is taken. It runs at half the reference rate while a lock counter counts reference ticks, and leaves by transition *expire* back to STABLE when the count runs out. **LIMP** is entered by transition *lose* from either other state when the reference tick stops arriving. It runs at a fixed slow rate and is left only by reset. A multiplier write made during RELOCK restarts the count through transition *restart*.

The ordering rules of the control registers are enforced in hardware. Changing the multiplier needs the divide selection at its reset value. Divide-by-1 can only be reached from divide-by-2. Nothing at all can be written while the protect flag is clear.

Top module: `clkseq_top`

Register map (address on `wr_addr`/`rd_addr`): 0 guard (bit 0 = protect release, always writable); 1 multiplier (bits 3:0); 2 control (bits 1:0 divide select, bit 2 detector disable; read-only bit 8 lock, bit 9 missing-clock); 3 prescalers (bits 2:0 high-speed field, bits 6:4 low-speed field).

## Requirements
- R1: After reset the state is as follows. The multiplier is 0, the divide select is 0, the detector disable is 0 and the guard bit is 0. The high-speed field is 1 and the low-speed field is 2, so address 3 reads 0x21. `locked` is 1 and `miss_clk` is 0. `sys_ce` pulses once every 4*REF_PERIOD core cycles.
- R2: While guard bit 0 is clear, writes to addresses 1, 2 and 3 leave every register unchanged. Writing address 0 sets or clears the guard bit at any time.
- R3: A write to address 1 takes effect only under four conditions: the guard bit is set, the divide select is 0, the value is at most MULT_MAX (10), and the value differs from the current multiplier. Otherwise the multiplier keeps its value.
- R4: `locked` drops on the same clock edge that an accepted multiplier write updates the register. The sequencer then enters RELOCK, and `sys_ce` averages one pulse per 2*REF_PERIOD cycles regardless of the divide select.
- R5: `locked` stays 0 after LOCK_TICKS-1 reference ticks that follow the accept. It is 1 after the LOCK_TICKS-th tick. From then on, `sys_ce` averages max(mult,1)*(4/div) pulses per 4*REF_PERIOD cycles, exactly, over any window of a multiple of 4*REF_PERIOD cycles.
- R6: The divide select encodes the divider as follows: 0 and 1 give divide-by-4, 2 gives divide-by-2 and 3 gives divide-by-1.
- R7: A write of 3 to the divide select takes effect only when the current value is 2. Otherwise the divide select keeps its value. Values 0, 1 and 2 are always accepted.
- R8: A prescaler field f of 1 to 7 gives one output pulse per 2*f `sys_ce` pulses. A field of 0 passes every `sys_ce` pulse. Every `hs_ce` and `ls_ce` pulse coincides with a `sys_ce` pulse.
- R9: If no reference tick arrives for MISS_WIN core cycles while the detector disable is 0, `miss_clk` sets and stays set until reset. `locked` goes to 0, and `sys_ce` falls back to one pulse per 4*REF_PERIOD cycles.
- R10: While the detector disable (address 2, bit 2) is 1, a missing reference tick does not set `miss_clk`.
- R11: A multiplier of 0 bypasses the multiply. The system rate is then the reference rate divided by the post-divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| sys_ce | output | 1 | System clock-enable pulse |
| hs_ce | output | 1 | High-speed peripheral clock-enable pulse |
| ls_ce | output | 1 | Low-speed peripheral clock-enable pulse |
| locked | output | 1 | Lock status |
| miss_clk | output | 1 | Sticky missing-reference flag |

## Verification
The hardest situation to reach from the ports is the exact lock boundary. The bench must show that `locked` is still low one reference tick before expiry and high right after it, while a rate window is being measured at the relock rate. The bench keeps its own count of the reference ticks it drives, takes a snapshot right after the accepting write, and samples `locked` when its count reaches LOCK_TICKS-1 and LOCK_TICKS. Reaching the divide-by-1 rates needs the exact write order 0, accept, lock, 2, 3. Missing-clock entry is reached by halting the tick generator, first with the detector disabled and then enabled.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    typedef enum logic [1:0] {
        ST_STABLE = 2'd0,
        ST_RELOCK = 2'd1,
        ST_LIMP   = 2'd2
    } seq_state_e;

    localparam logic [1:0] A_GUARD = 2'd0;
    localparam logic [1:0] A_MULT  = 2'd1;
    localparam logic [1:0] A_CTRL  = 2'd2;
    localparam logic [1:0] A_PRESC = 2'd3;

    localparam logic [1:0] DS_QUARTER = 2'd0;
    localparam logic [1:0] DS_HALF    = 2'd2;
    localparam logic [1:0] DS_FULL    = 2'd3;

    localparam int LS_LSB  = 4;
    localparam int DET_BIT = 2;
    localparam int LCK_BIT = 8;
    localparam int MIS_BIT = 9;

endpackage

// File: rtl/clkseq_regs.sv
module clkseq_regs
    import clkseq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int MULT_W   = 4,
    parameter int MULT_MAX = 10,
    parameter int PRE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prot_q,
    output logic [MULT_W-1:0] mult_q,
    output logic [1:0]        dsel_q,
    output logic              det_off_q,
    output logic [PRE_W-1:0]  hs_div,
    output logic [PRE_W-1:0]  ls_div,
    output logic              mult_acc
);

    localparam logic [MULT_W-1:0] MULT_LIM = MULT_W'(MULT_MAX);

    logic [MULT_W-1:0] wr_mult;
    logic [1:0]        wr_dsel;
    logic              wr_ctrl, wr_pre, dsel_ok;
    logic              unused_wr;

    assign wr_mult   = wr_data[MULT_W-1:0];
    assign wr_dsel   = wr_data[1:0];
    assign unused_wr = ^wr_data;

    assign mult_acc = wr_en && prot_q && (wr_addr == A_MULT) &&
                      (dsel_q == DS_QUARTER) && (wr_mult <= MULT_LIM) &&
                      (wr_mult != mult_q);
    assign wr_ctrl  = wr_en && prot_q && (wr_addr == A_CTRL);
    assign wr_pre   = wr_en && prot_q && (wr_addr == A_PRESC);
    assign dsel_ok  = (wr_dsel != DS_FULL) || (dsel_q == DS_HALF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q    <= 1'b0;
            mult_q    <= '0;
            dsel_q    <= DS_QUARTER;
            det_off_q <= 1'b0;
            hs_div    <= PRE_W'(1);
            ls_div    <= PRE_W'(2);
        end else begin
            if (wr_en && (wr_addr == A_GUARD))
                prot_q <= wr_data[0];
            if (mult_acc)
                mult_q <= wr_mult;
            if (wr_ctrl) begin
                det_off_q <= wr_data[DET_BIT];
                if (dsel_ok)
                    dsel_q <= wr_dsel;
            end
            if (wr_pre) begin
                hs_div <= wr_data[PRE_W-1:0];
                ls_div <= wr_data[LS_LSB +: PRE_W];
            end
        end
    end

endmodule

// File: rtl/clkseq_seq.sv
module clkseq_seq
    import clkseq_pkg::*;
#(
    parameter int LOCK_TICKS = 1024,
    parameter int MISS_WIN   = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       mult_acc,
    input  logic       det_off,
    output seq_state_e state_o,
    output logic       locked,
    output logic       miss
);

    localparam int LCW = $clog2(LOCK_TICKS + 1);
    localparam int GW  = $clog2(MISS_WIN + 1);
    localparam logic [LCW-1:0] LOCK_INIT = LCW'(LOCK_TICKS);
    localparam logic [GW-1:0]  GAP_LIM   = GW'(MISS_WIN);

    seq_state_e     state_q, state_d;
    logic [LCW-1:0] lock_cnt;
    logic [GW-1:0]  gap_q;
    logic           miss_q, miss_set, expire;

    assign miss_set = (gap_q >= GAP_LIM) && !det_off && !miss_q;
    assign expire   = ref_tick && (lock_cnt == LCW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STABLE;
        else        state_q <= state_d;
    end

    // transitions: accept, restart, expire, lose
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STABLE: begin
                if (miss_set)      state_d = ST_LIMP;
                else if (mult_acc) state_d = ST_RELOCK;
            end
            ST_RELOCK: begin
                if (miss_set)      state_d = ST_LIMP;
                else if (mult_acc) state_d = ST_RELOCK;
                else if (expire)   state_d = ST_STABLE;
            end
            ST_LIMP:               state_d = ST_LIMP;
            default:               state_d = ST_LIMP;
        endcase
    end

    // outputs
    always_comb begin
        state_o = state_q;
        locked  = (state_q == ST_STABLE);
        miss    = miss_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_cnt <= '0;
            gap_q    <= '0;
            miss_q   <= 1'b0;
        end else begin
            if (mult_acc && (state_q != ST_LIMP))
                lock_cnt <= LOCK_INIT;
            else if ((state_q == ST_RELOCK) && ref_tick && (lock_cnt != '0))
                lock_cnt <= lock_cnt - LCW'(1);
            if (ref_tick)
                gap_q <= '0;
            else if (gap_q != GAP_LIM)
                gap_q <= gap_q + GW'(1);
            if (miss_set)
                miss_q <= 1'b1;
        end
    end

endmodule

// File: rtl/clkseq_rate.sv
module clkseq_rate
    import clkseq_pkg::*;
#(
    parameter int REF_PERIOD = 16,
    parameter int MULT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic [MULT_W-1:0] mult_q,
    input  logic [1:0]        dsel_q,
    output logic              sys_ce
);

    localparam int DEN   = 4 * REF_PERIOD;
    localparam int NUM_W = MULT_W + 3;
    localparam int ACC_W = $clog2(DEN + (1 << NUM_W)) + 1;
    localparam logic [ACC_W-1:0] DEN_V = ACC_W'(DEN);

    logic [NUM_W-1:0] m_eff, num;
    logic [ACC_W-1:0] acc_q, sum;

    always_comb begin
        m_eff = (mult_q == '0) ? NUM_W'(1) : NUM_W'(mult_q);
        unique case (state)
            ST_RELOCK: num = NUM_W'(2);
            ST_LIMP:   num = NUM_W'(1);
            default: begin
                unique case (dsel_q)
                    DS_FULL: num = m_eff << 2;
                    DS_HALF: num = m_eff << 1;
                    default: num = m_eff;
                endcase
            end
        endcase
        sum = acc_q + ACC_W'(num);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            sys_ce <= 1'b0;
        end else if (sum >= DEN_V) begin
            acc_q  <= sum - DEN_V;
            sys_ce <= 1'b1;
        end else begin
            acc_q  <= sum;
            sys_ce <= 1'b0;
        end
    end

endmodule

// File: rtl/clkseq_presc.sv
module clkseq_presc #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_ce,
    input  logic [PRE_W-1:0] field,
    output logic             ce_out
);

    localparam int CNT_W = PRE_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last   = (field == '0) || (cnt_q >= ({field, 1'b0} - CNT_W'(1)));
    assign ce_out = sys_ce && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (sys_ce)
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/clkseq_top.sv
module clkseq_top
    import clkseq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int MULT_W     = 4,
    parameter int MULT_MAX   = 10,
    parameter int PRE_W      = 3,
    parameter int REF_PERIOD = 16,
    parameter int LOCK_TICKS = 1024,
    parameter int MISS_WIN   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              sys_ce,
    output logic              hs_ce,
    output logic              ls_ce,
    output logic              locked,
    output logic              miss_clk
);

    localparam int N_PRE = 2;

    logic              prot_q, det_off_q, mult_acc;
    logic [MULT_W-1:0] mult_q;
    logic [1:0]        dsel_q;
    logic [PRE_W-1:0]  hs_div, ls_div;
    logic [PRE_W-1:0]  pre_div [N_PRE];
    logic [N_PRE-1:0]  pre_ce;
    seq_state_e        state;

    clkseq_regs #(
        .DATA_W(DATA_W), .MULT_W(MULT_W), .MULT_MAX(MULT_MAX), .PRE_W(PRE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prot_q(prot_q), .mult_q(mult_q), .dsel_q(dsel_q),
        .det_off_q(det_off_q), .hs_div(hs_div), .ls_div(ls_div),
        .mult_acc(mult_acc)
    );

    clkseq_seq #(
        .LOCK_TICKS(LOCK_TICKS), .MISS_WIN(MISS_WIN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .mult_acc(mult_acc),
        .det_off(det_off_q), .state_o(state), .locked(locked), .miss(miss_clk)
    );

    clkseq_rate #(
        .REF_PERIOD(REF_PERIOD), .MULT_W(MULT_W)
    ) u_rate (
        .clk(clk), .rst_n(rst_n), .state(state), .mult_q(mult_q),
        .dsel_q(dsel_q), .sys_ce(sys_ce)
    );

    assign pre_div[0] = hs_div;
    assign pre_div[1] = ls_div;

    for (genvar g = 0; g < N_PRE; g++) begin : g_pre
        clkseq_presc #(.PRE_W(PRE_W)) u_pre (
            .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce),
            .field(pre_div[g]), .ce_out(pre_ce[g])
        );
    end

    assign hs_ce = pre_ce[0];
    assign ls_ce = pre_ce[1];

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_GUARD: rd_data[0] = prot_q;
            A_MULT:  rd_data[MULT_W-1:0] = mult_q;
            A_CTRL: begin
                rd_data[1:0]     = dsel_q;
                rd_data[DET_BIT] = det_off_q;
                rd_data[LCK_BIT] = locked;
                rd_data[MIS_BIT] = miss_clk;
            end
            default: begin
                rd_data[PRE_W-1:0]      = hs_div;
                rd_data[LS_LSB +: PRE_W] = ls_div;
            end
        endcase
    end

endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk #(
    parameter int MULT_W   = 4,
    parameter int PRE_W    = 3,
    parameter int MULT_MAX = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prot_q,
    input logic [MULT_W-1:0] mult_q,
    input logic [1:0]        dsel_q,
    input logic [PRE_W-1:0]  hs_div,
    input logic [PRE_W-1:0]  ls_div,
    input logic              locked,
    input logic              miss_clk,
    input logic              sys_ce,
    input logic              hs_ce,
    input logic              ls_ce
);

    localparam logic [MULT_W-1:0] MULT_LIM = MULT_W'(MULT_MAX);

    p_prot_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_q |=> ($stable(mult_q) && $stable(dsel_q) &&
                     $stable(hs_div) && $stable(ls_div)));

    p_mult_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel_q != 2'd0) |=> $stable(mult_q));

    p_mult_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mult_q <= MULT_LIM);

    p_lock_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mult_q) |-> !locked);

    p_div1_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dsel_q != 2'd2) && (dsel_q != 2'd3)) |=> (dsel_q != 2'd3));

    p_presc_sub_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_ce || ls_ce) |-> sys_ce);

    p_miss_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_clk |=> miss_clk);

    p_limp_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_clk |-> !locked);

endmodule

bind clkseq_top clkseq_chk #(
    .MULT_W(MULT_W), .PRE_W(PRE_W), .MULT_MAX(MULT_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .prot_q(prot_q), .mult_q(mult_q),
    .dsel_q(dsel_q), .hs_div(hs_div), .ls_div(ls_div), .locked(locked),
    .miss_clk(miss_clk), .sys_ce(sys_ce), .hs_ce(hs_ce), .ls_ce(ls_ce)
);

// File: tb/clkseq_top_test.sv
module clkseq_top_test;

    localparam int REFP  = 16;
    localparam int LOCKT = 100;
    localparam int MISSW = 64;
    localparam int WIN   = 1024;

    logic        clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    wire  [15:0] rd_data;
    wire         sys_ce, hs_ce, ls_ce, locked, miss_clk;

    int checks = 0, fails = 0, tick_seen = 0, done_cnt = 0;
    bit ref_on = 1'b1;

    typedef struct { string tag; int s; int h; int l; } exp_t;
    exp_t sb_q[$];

    clkseq_top #(.REF_PERIOD(REFP), .LOCK_TICKS(LOCKT), .MISS_WIN(MISSW)) uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .sys_ce(sys_ce), .hs_ce(hs_ce), .ls_ce(ls_ce),
        .locked(locked), .miss_clk(miss_clk)
    );

    always #10 clk = ~clk;

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (ref_on && rst_n) begin
                ph = (ph + 1) % REFP;
                ref_tick = (ph == 0);
            end else
                ref_tick = 1'b0;
        end
    end

    always @(posedge clk) if (ref_tick) tick_seen <= tick_seen + 1;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    // driver: push expected pulse counts, wait for the monitor to judge them
    task automatic expect_rate(string tag, int s, int h, int l);
        exp_t e;
        int target;
        repeat (4) @(negedge clk);
        e.tag = tag; e.s = s; e.h = h; e.l = l;
        target = done_cnt + 1;
        sb_q.push_back(e);
        while (done_cnt < target) @(negedge clk);
    endtask

    // monitor: count pulses over one window and compare with the queue head
    initial begin
        forever begin
            exp_t e;
            int ns, nh, nl;
            while (sb_q.size() == 0) @(negedge clk);
            e = sb_q[0];
            ns = 0; nh = 0; nl = 0;
            repeat (WIN) begin
                @(negedge clk);
                ns += int'(sys_ce); nh += int'(hs_ce); nl += int'(ls_ce);
            end
            void'(sb_q.pop_front());
            check(e.tag, "sys_ce count", ns, e.s);
            check(e.tag, "hs_ce count", nh, e.h);
            check(e.tag, "ls_ce count", nl, e.l);
            done_cnt++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog all requirements: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int v, t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "locked", int'(locked), 1);
        check("R1", "miss_clk", int'(miss_clk), 0);
        rd(2'd1, v); check("R1", "mult", v, 0);
        rd(2'd2, v); check("R1", "ctrl", v & 16'h7, 0);
        rd(2'd3, v); check("R1", "presc", v, 16'h21);
        rd(2'd0, v); check("R1", "guard", v, 0);
        expect_rate("R1", 16, 8, 4);

        // R2 protected writes dropped
        wr(2'd1, 16'd5);
        rd(2'd1, v); check("R2", "mult while protected", v, 0);
        check("R2", "locked while protected", int'(locked), 1);
        wr(2'd3, 16'h00);
        rd(2'd3, v); check("R2", "presc while protected", v, 16'h21);
        wr(2'd0, 16'd1);
        rd(2'd0, v); check("R2", "guard set", v, 1);

        // R6 / R11 divide-by-2 with bypass multiplier
        wr(2'd2, 16'd2);
        rd(2'd2, v); check("R6", "dsel 2", v & 3, 2);
        expect_rate("R11", 32, 16, 8);

        // R3 ordering and range
        wr(2'd1, 16'd5);
        rd(2'd1, v); check("R3", "mult with dsel 2", v, 0);
        wr(2'd2, 16'd0);
        wr(2'd2, 16'd3);
        rd(2'd2, v); check("R7", "dsel 3 from 0", v & 3, 0);
        wr(2'd1, 16'd11);
        rd(2'd1, v); check("R3", "mult 11", v, 0);

        // R4 accept and relock rate
        wr(2'd1, 16'd5);
        t0 = tick_seen;
        check("R4", "locked after accept", int'(locked), 0);
        rd(2'd1, v); check("R3", "mult accepted", v, 5);
        expect_rate("R4", 32, 16, 8);

        // R5 lock boundary
        while (tick_seen < t0 + LOCKT - 1) @(negedge clk);
        check("R5", "locked one tick early", int'(locked), 0);
        while (tick_seen < t0 + LOCKT) @(negedge clk);
        @(negedge clk);
        check("R5", "locked at expiry", int'(locked), 1);
        expect_rate("R5", 80, 40, 20);

        wr(2'd2, 16'd2);
        expect_rate("R6", 160, 80, 40);
        wr(2'd2, 16'd3);
        rd(2'd2, v); check("R7", "dsel 3 from 2", v & 3, 3);
        expect_rate("R6", 320, 160, 80);

        wr(2'd1, 16'd7);
        rd(2'd1, v); check("R3", "mult with dsel 3", v, 5);
        check("R3", "locked kept", int'(locked), 1);

        // R8 prescaler pass-through and divide-by-8
        wr(2'd3, 16'h40);
        expect_rate("R8", 320, 320, 40);

        wr(2'd2, 16'd1);
        rd(2'd2, v); check("R6", "dsel 1", v & 3, 1);
        expect_rate("R6", 80, 80, 10);
        wr(2'd2, 16'd3);
        rd(2'd2, v); check("R7", "dsel 3 from 1", v & 3, 1);

        // R5 maximum multiplier at divide-by-1
        wr(2'd2, 16'd0);
        wr(2'd1, 16'd10);
        check("R4", "locked after accept 10", int'(locked), 0);
        while (!locked) @(negedge clk);
        wr(2'd2, 16'd2);
        wr(2'd2, 16'd3);
        expect_rate("R5", 640, 640, 80);

        // R11 bypass after relock
        wr(2'd2, 16'd0);
        wr(2'd1, 16'd0);
        check("R4", "locked after accept 0", int'(locked), 0);
        while (!locked) @(negedge clk);
        expect_rate("R11", 16, 16, 2);

        // R2 guard cleared again
        wr(2'd0, 16'd0);
        wr(2'd2, 16'd2);
        rd(2'd2, v); check("R2", "dsel after guard clear", v & 3, 0);
        wr(2'd0, 16'd1);

        // R10 detector disabled
        wr(2'd2, 16'd4);
        ref_on = 1'b0;
        repeat (200) @(negedge clk);
        check("R10", "miss with detector off", int'(miss_clk), 0);
        check("R10", "locked with detector off", int'(locked), 1);
        ref_on = 1'b1;
        repeat (40) @(negedge clk);
        wr(2'd2, 16'd0);
        repeat (20) @(negedge clk);

        // R9 missing reference
        ref_on = 1'b0;
        repeat (200) @(negedge clk);
        check("R9", "miss set", int'(miss_clk), 1);
        check("R9", "locked in limp", int'(locked), 0);
        ref_on = 1'b1;
        repeat (100) @(negedge clk);
        check("R9", "miss sticky", int'(miss_clk), 1);
        rd(2'd2, v); check("R9", "miss readback", (v >> 9) & 1, 1);
        expect_rate("R9", 16, 16, 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule